// File: doc/BRIEF.md
# Multi-view floating-point register file

This block holds sixty-four 32-bit single-precision registers and lets a core see the same storage in four shapes. A register can be read or written on its own, as an adjacent pair forming a 64-bit double, as a group of four forming a 128-bit vector, or as the first row of a sixteen-register matrix. All four shapes alias the same cells, so a value written as a double can be read back as two singles, and a vector write can be seen as four singles.

There is one read port and one write port. Each port has a 2-bit view selector and a 6-bit index. Data travels in a 128-bit word, with the lowest-addressed register of a group in the most significant used slot. Writes take effect on the rising clock edge. Reads are combinational from the stored contents.

Top module: `fprf_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears all 64 registers to zero. After reset, every view and index reads back zero.
- R2: The view code is 0 for single, 1 for double, 2 for vector and 3 for matrix. A single read at index n returns register n in bits [31:0] and zeros in bits [127:32]. A single write stores `wr_data[31:0]` into register n.
- R3: A double read at index n returns register n in bits [63:32], register n+1 in bits [31:0] and zeros in bits [127:64].
- R4: A double write at index n stores `wr_data[63:32]` into register n and `wr_data[31:0]` into register n+1.
- R5: A double access at index 63 uses register 0 as its second word, for both read and write.
- R6: A vector read uses only index bits [3:0] and forms base b = 4*idx[3:0]. It returns register b in [127:96], b+1 in [95:64], b+2 in [63:32] and b+3 in [31:0].
- R7: A vector write uses the same base and slot placement as a vector read and stores all four registers.
- R8: A matrix access uses only index bits [1:0] and forms base b = 16*idx[1:0]. It reads or writes registers b..b+3 with the vector slot placement.
- R9: A write is visible at `rd_data` in the cycle after its clock edge, with no further read latency.
- R10: While `wr_en` is low, the write view, index and data have no effect on any register.
- R11: A write changes only the registers its view and index address. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_view | input | 2 | Write view: 0 single, 1 double, 2 vector, 3 matrix |
| wr_idx | input | 6 | Write index |
| wr_data | input | 128 | Write data, slot placement per view |
| rd_view | input | 2 | Read view: 0 single, 1 double, 2 vector, 3 matrix |
| rd_idx | input | 6 | Read index |
| rd_data | output | 128 | Read data, unused upper slots zero |

## Verification
The hardest cases to reach are the aliasing corners. One is a double at index 63 whose second word lands in register 0. The others are the vector and matrix views, whose upper index bits must be dropped rather than carried into the base. The stimulus first loads every register with a distinct value through the single view. It then writes through the double, vector and matrix views using indices with upper bits set, and the 63 wrap. After each step it sweeps every view at all 64 indices, so every alias of every register is compared against an arithmetic model.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_REGS   = 64;
    localparam int LANES      = 4;
    localparam int IDX_W      = $clog2(NUM_REGS);
    localparam int DATA_W     = WORD_W * LANES;
    localparam int VEC_GROUPS = NUM_REGS / LANES;
    localparam int MTX_STRIDE = LANES * LANES;
    localparam int MTX_GROUPS = NUM_REGS / MTX_STRIDE;

    typedef enum logic [1:0] {
        VIEW_SINGLE = 2'd0,
        VIEW_PAIR   = 2'd1,
        VIEW_QUAD   = 2'd2,
        VIEW_BLOCK  = 2'd3
    } view_e;

    typedef struct packed {
        logic [LANES-1:0]            act;
        logic [LANES-1:0][IDX_W-1:0] addr;
    } lane_map_t;

    // Slot s carries lane j = cnt-1-s, so the lowest register of a group
    // sits in the highest used slot.
    function automatic lane_map_t map_lanes(view_e v, logic [IDX_W-1:0] idx);
        lane_map_t        m;
        logic [IDX_W-1:0] base;
        int               cnt;
        m = '0;
        unique case (v)
            VIEW_SINGLE: begin base = idx; cnt = 1; end
            VIEW_PAIR:   begin base = idx; cnt = 2; end
            VIEW_QUAD: begin
                base = IDX_W'((int'(idx) % VEC_GROUPS) * LANES);
                cnt  = LANES;
            end
            default: begin
                base = IDX_W'((int'(idx) % MTX_GROUPS) * MTX_STRIDE);
                cnt  = LANES;
            end
        endcase
        for (int s = 0; s < LANES; s++) begin
            if (s < cnt) begin
                m.act[s]  = 1'b1;
                m.addr[s] = base + IDX_W'(cnt - 1 - s);
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/fprf_lane_map.sv
module fprf_lane_map
    import fprf_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic [1:0]    view,
    input  logic [IW-1:0] idx,
    output lane_map_t     map
);
    always_comb map = map_lanes(view_e'(view), idx);
endmodule

// File: rtl/fprf_store.sv
module fprf_store
    import fprf_pkg::*;
#(
    parameter int NR = NUM_REGS,
    parameter int W  = WORD_W,
    parameter int NL = LANES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  lane_map_t              wmap,
    input  logic [NL*W-1:0]        wdata,
    output logic [NR-1:0][W-1:0]   regs_q
);
    for (genvar r = 0; r < NR; r++) begin : g_reg
        logic         hit;
        logic [W-1:0] nxt;
        always_comb begin
            hit = 1'b0;
            nxt = regs_q[r];
            for (int s = 0; s < NL; s++) begin
                if (wmap.act[s] && (int'(wmap.addr[s]) == r)) begin
                    hit = 1'b1;
                    nxt = wdata[s*W +: W];
                end
            end
        end
        always_ff @(posedge clk) begin
            if (rst)             regs_q[r] <= '0;
            else if (we && hit)  regs_q[r] <= nxt;
        end
    end
endmodule

// File: rtl/fprf_read.sv
module fprf_read
    import fprf_pkg::*;
#(
    parameter int NR = NUM_REGS,
    parameter int W  = WORD_W,
    parameter int NL = LANES
) (
    input  logic [NR-1:0][W-1:0] regs_q,
    input  lane_map_t            rmap,
    output logic [NL*W-1:0]      rdata
);
    for (genvar s = 0; s < NL; s++) begin : g_slot
        assign rdata[s*W +: W] = rmap.act[s] ? regs_q[rmap.addr[s]] : '0;
    end
endmodule

// File: rtl/fprf_regfile.sv
module fprf_regfile
    import fprf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_view,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_view,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    lane_map_t                       wmap, rmap;
    logic [NUM_REGS-1:0][WORD_W-1:0] store_q;

    fprf_lane_map i_wmap (.view(wr_view), .idx(wr_idx), .map(wmap));
    fprf_lane_map i_rmap (.view(rd_view), .idx(rd_idx), .map(rmap));

    fprf_store i_store (
        .clk(clk), .rst(rst), .we(wr_en), .wmap(wmap),
        .wdata(wr_data), .regs_q(store_q)
    );

    fprf_read i_read (.regs_q(store_q), .rmap(rmap), .rdata(rd_data));
endmodule

// File: rtl/fprf_regfile_chk.sv
module fprf_regfile_chk
    import fprf_pkg::*;
(
    input logic                            clk,
    input logic                            rst,
    input logic                            wr_en,
    input logic [1:0]                      wr_view,
    input logic [IDX_W-1:0]                wr_idx,
    input logic [DATA_W-1:0]               wr_data,
    input logic [1:0]                      rd_view,
    input logic [IDX_W-1:0]                rd_idx,
    input logic [DATA_W-1:0]               rd_data,
    input logic [NUM_REGS-1:0][WORD_W-1:0] store_q
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (store_q == '0));

    assert_single_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_view == 2'd0) |-> (rd_data[DATA_W-1:WORD_W] == '0 &&
                               rd_data[WORD_W-1:0] == store_q[rd_idx]));

    assert_double_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_view == 2'd1) |-> (rd_data[DATA_W-1:2*WORD_W] == '0 &&
                               rd_data[2*WORD_W-1:WORD_W] == store_q[rd_idx]));

    assert_double_write_hi_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view == 2'd1) |=>
            (store_q[$past(wr_idx)] == $past(wr_data[2*WORD_W-1:WORD_W])));

    assert_double_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view == 2'd1 && wr_idx == IDX_W'(NUM_REGS-1)) |=>
            (store_q[0] == $past(wr_data[WORD_W-1:0])));

    assert_vector_base_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_view == 2'd2) |->
            (rd_data[DATA_W-1:DATA_W-WORD_W] == store_q[{rd_idx[3:0], 2'b00}]));

    assert_matrix_base_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_view == 2'd3) |->
            (rd_data[DATA_W-1:DATA_W-WORD_W] == store_q[{rd_idx[1:0], 4'b0000}]));

    assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(store_q));
endmodule

bind fprf_regfile fprf_regfile_chk i_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_view(wr_view), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_view(rd_view), .rd_idx(rd_idx), .rd_data(rd_data),
    .store_q(store_q)
);

// File: tb/test_fprf_regfile.sv
`timescale 1ns/1ps
module test_fprf_regfile;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_view = '0;
    logic [5:0]   wr_idx = '0;
    logic [127:0] wr_data = '0;
    logic [1:0]   rd_view = '0;
    logic [5:0]   rd_idx = '0;
    logic [127:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [31:0] model [64];

    always #2 clk = ~clk;

    fprf_regfile i_fprf_regfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_view(wr_view), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_view(rd_view), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    function automatic int grp_base(int v, int idx);
        if (v == 2) return (idx % 16) * 4;
        if (v == 3) return (idx % 4) * 16;
        return idx;
    endfunction

    function automatic logic [127:0] expect_rd(int v, int idx);
        int b;
        b = grp_base(v, idx);
        if (v == 0) return {96'b0, model[idx]};
        if (v == 1) return {64'b0, model[idx], model[(idx + 1) % 64]};
        return {model[b], model[b+1], model[b+2], model[b+3]};
    endfunction

    task automatic check(string tag, int v, int idx);
        logic [127:0] exp;
        rd_view = 2'(v);
        rd_idx  = 6'(idx);
        #0.5;
        exp = expect_rd(v, idx);
        n_checks++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s view=%0d idx=%0d actual=%h expected=%h",
                     tag, v, idx, rd_data, exp);
        end
    endtask

    task automatic sweep(string tag);
        for (int v = 0; v < 4; v++) begin
            for (int i = 0; i < 64; i++) begin
                string t;
                if (tag != "") t = tag;
                else if (v == 0) t = "R2";
                else if (v == 1) t = (i == 63) ? "R5" : "R3";
                else if (v == 2) t = "R6";
                else t = "R8";
                check(t, v, i);
            end
        end
    endtask

    task automatic write(int v, int idx, logic [127:0] d, bit en);
        int b;
        @(negedge clk);
        wr_en = en; wr_view = 2'(v); wr_idx = 6'(idx); wr_data = d;
        @(posedge clk);
        #0.5;
        wr_en = 1'b0;
        if (en) begin
            b = grp_base(v, idx);
            if (v == 0) model[idx] = d[31:0];
            else if (v == 1) begin
                model[idx] = d[63:32];
                model[(idx + 1) % 64] = d[31:0];
            end else begin
                model[b] = d[127:96]; model[b+1] = d[95:64];
                model[b+2] = d[63:32]; model[b+3] = d[31:0];
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < 64; r++) model[r] = '0;
    endtask

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        sweep("R1");

        // R2: fill every register through the single view
        for (int r = 0; r < 64; r++)
            write(0, r, {96'hdead, 8'(r), 8'(r * 7), 16'(16'hA500 + r)}, 1'b1);
        sweep("");

        // R9: visible right after the edge, no extra latency
        write(0, 12, 128'h5555_1234, 1'b1);
        check("R9", 0, 12);

        // R4 and R5: double writes, including the 63 wrap
        write(1, 10, {64'h0, 32'h1111_0010, 32'h2222_0011}, 1'b1);
        check("R4", 0, 10);
        check("R4", 0, 11);
        write(1, 63, {64'h0, 32'h6363_6363, 32'h0000_fade}, 1'b1);
        check("R5", 0, 63);
        check("R5", 0, 0);
        check("R5", 1, 63);
        check("R11", 0, 1);
        check("R11", 0, 62);
        sweep("");

        // R7: vector writes with upper index bits set
        for (int g = 0; g < 16; g++)
            write(2, 16 + g, {32'(32'hC000_0000 + g*4), 32'(32'hC100_0001 + g*4),
                              32'(32'hC200_0002 + g*4), 32'(32'hC300_0003 + g*4)}, 1'b1);
        check("R7", 0, 20);
        check("R7", 0, 23);
        check("R7", 2, 53);
        sweep("");

        // R8: matrix write at index 7 lands at base 48
        write(3, 7, {32'hAAAA_0030, 32'hBBBB_0031, 32'hCCCC_0032, 32'hDDDD_0033}, 1'b1);
        check("R8", 0, 48);
        check("R8", 0, 51);
        check("R11", 0, 52);
        check("R11", 0, 47);
        sweep("");

        // R10: wr_en low ignored for every view
        for (int v = 0; v < 4; v++)
            write(v, 5, {4{32'hFFFF_FFFF}}, 1'b0);
        sweep("R10");

        do_reset();
        sweep("R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule